// File: doc/BRIEF.md
# Message Buffer ECC Error Handler

This block sits beside the message handler of a communication controller and collects the ECC error reports raised on its six transfer paths. Those paths are: input buffer to message RAM, host read of an input buffer, header scan of message RAM, message RAM to transient buffer, transient buffer to channel 1, and transient buffer to channel 2. Each path gives a single-bit strobe and a multi-bit strobe. The input-buffer transfer also carries a tag that marks a data-only transfer. Three buffer-number buses say which message buffer the transfer, the scan and the transient copy were working on.

On a multi-bit error the block does two things in the same cycle. It issues single-cycle suppression pulses to the frame engine: block the transmit request, withhold the data write, skip the buffer, drop the frame, or force the CRC to zero on channel 1 or 2. It also sets sticky status flags that software clears by writing ones. The first faulty buffer number is held by a two-state machine with states `IDX_EMPTY` and `IDX_HELD`. Transition `T_CAPTURE` goes from EMPTY to HELD when a capturing path reports an error. `T_RELEASE` goes from HELD to EMPTY when software clears the valid bit. `T_RECAPTURE` stays in HELD when a clear and a new capture fall in the same cycle, and takes the new number. One interrupt line combines the general-error flag and the single-bit flag, each gated by its own enable.

Top module: `ecch_top`

## Requirements
- R1: Any single-bit or multi-bit strobe sets the general error flag `st_flags_o[6]` at the next clock. `irq_o` is high while that flag is set and `irq_err_en_i` is 1.
- R2: A single-bit strobe on path p sets the single-bit flag `st_flags_o[5]` and the location bit `st_sbe_path_o[p]`. It raises no suppression pulse and no fault flag. `irq_o` is also high while `st_flags_o[5]` is set and `irq_sbe_en_i` is 1.
- R3: A multi-bit error on path 0 (input buffer to RAM) with `xfer_data_only_i`=0 sets the input-buffer flag `st_flags_o[0]`. It latches `xfer_buf_i` and pulses `block_txreq_o` without `hold_data_o`.
- R4: A multi-bit error on path 0 with `xfer_data_only_i`=1 sets the message-RAM flag `st_flags_o[1]`. It latches `xfer_buf_i` and pulses both `block_txreq_o` and `hold_data_o`.
- R5: A multi-bit error on path 1 (host read) sets only `st_flags_o[0]` and the general flag. No number is latched and no pulse is issued.
- R6: A multi-bit error on path 2 (header scan) sets `st_flags_o[1]`, latches `scan_buf_i` and pulses `skip_buf_o`.
- R7: A multi-bit error on path 3 (RAM to transient buffer) sets `st_flags_o[1]`, latches `tbuf_buf_i` and pulses `frame_drop_o`. It also pulses `crc_zero_o[k]` for each channel k set in `tbuf_ch_i`.
- R8: A multi-bit error on path 4 or 5 sets `st_flags_o[2]` (channel 1) or `st_flags_o[3]` (channel 2), and pulses `crc_zero_o[0]` or `crc_zero_o[1]` respectively.
- R9: Flags are sticky. A clear write (`clr_we_i`=1) clears the flags whose `clr_mask_i` bits are 1. The mask layout is bits [6:0] = flag bits in `st_flags_o` order and bits [12:7] = `st_sbe_path_o`. When a set and a clear hit the same flag in the same cycle, the set wins.
- R10: The latched number `st_idx_o` and the valid flag `st_flags_o[4]` hold the first captured value until valid is cleared. The number then reads 0.
- R11: When several paths report in one cycle, all their flags and pulses appear. The number is taken from the scan first, then the input-buffer transfer, then the transient copy.
- R12: Suppression pulses are combinational in the strobe's cycle and last only while the strobe is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sbe_i | input | 6 | Single-bit error strobe per path |
| mbe_i | input | 6 | Multi-bit error strobe per path |
| xfer_data_only_i | input | 1 | Path 0 transfer is data-only |
| tbuf_ch_i | input | 2 | Channels with a frame in flight for path 3 |
| xfer_buf_i | input | BUF_W | Buffer number of the input-buffer transfer |
| scan_buf_i | input | BUF_W | Buffer number under header scan |
| tbuf_buf_i | input | BUF_W | Buffer number being copied to a transient buffer |
| clr_we_i | input | 1 | Clear write strobe |
| clr_mask_i | input | 13 | Write-one-to-clear mask |
| irq_err_en_i | input | 1 | Enable for the general error interrupt |
| irq_sbe_en_i | input | 1 | Enable for the single-bit interrupt |
| st_flags_o | output | 7 | {err, sbe, idx_valid, ch2, ch1, mram, ibf} |
| st_sbe_path_o | output | 6 | Sticky single-bit location per path |
| st_idx_o | output | BUF_W | Latched faulty buffer number |
| irq_o | output | 1 | Interrupt |
| block_txreq_o | output | 1 | Pulse: do not set the transmit request |
| hold_data_o | output | 1 | Pulse: do not write the data section |
| skip_buf_o | output | 1 | Pulse: skip the scanned buffer |
| frame_drop_o | output | 1 | Pulse: do not send the frame |
| crc_zero_o | output | 2 | Pulse per channel: force the outgoing CRC to zero |

## Verification
Two things can land in the same cycle. One is a software clear. The other is a fresh error that sets the same flag or captures a new buffer number. The bench issues the clear write in the very cycle a strobe arrives. It then judges that the flag survives, and that after a clear of the valid bit the new number is taken instead of 0. Several paths reporting at once are also driven from the vector table. That checks that every flag and pulse appears together and that the number follows the scan, transfer, transient priority.

// File: rtl/ecch_pkg.sv
package ecch_pkg;
    localparam int NPATH   = 6;
    localparam int P_XFER  = 0;
    localparam int P_HOST  = 1;
    localparam int P_SCAN  = 2;
    localparam int P_TBUF  = 3;
    localparam int P_CH1   = 4;
    localparam int P_CH2   = 5;
    localparam int NFLAG   = 7;
    localparam int F_IBF   = 0;
    localparam int F_MRAM  = 1;
    localparam int F_CH1   = 2;
    localparam int F_CH2   = 3;
    localparam int F_VALID = 4;
    localparam int F_SBE   = 5;
    localparam int F_ERR   = 6;
    localparam int CLR_W   = NFLAG + NPATH;
    localparam int STICKY_W = CLR_W - 1;

    typedef enum logic {IDX_EMPTY, IDX_HELD} idx_state_e;

    typedef struct packed {
        logic ibf;
        logic mram;
        logic ch1;
        logic ch2;
        logic cap_scan;
        logic cap_xfer;
        logic cap_tbuf;
    } fault_t;
endpackage

// File: rtl/ecch_path_decode.sv
module ecch_path_decode
    import ecch_pkg::*;
(
    input  logic [NPATH-1:0] mbe_i,
    input  logic             data_only_i,
    input  logic [1:0]       tbuf_ch_i,
    output fault_t           fault_o,
    output logic             block_txreq_o,
    output logic             hold_data_o,
    output logic             skip_buf_o,
    output logic             frame_drop_o,
    output logic [1:0]       crc_zero_o
);
    always_comb begin
        fault_o.ibf      = (mbe_i[P_XFER] & ~data_only_i) | mbe_i[P_HOST];
        fault_o.mram     = (mbe_i[P_XFER] & data_only_i) | mbe_i[P_SCAN] | mbe_i[P_TBUF];
        fault_o.ch1      = mbe_i[P_CH1];
        fault_o.ch2      = mbe_i[P_CH2];
        fault_o.cap_scan = mbe_i[P_SCAN];
        fault_o.cap_xfer = mbe_i[P_XFER];
        fault_o.cap_tbuf = mbe_i[P_TBUF];
    end

    always_comb begin
        block_txreq_o = mbe_i[P_XFER];
        hold_data_o   = mbe_i[P_XFER] & data_only_i;
        skip_buf_o    = mbe_i[P_SCAN];
        frame_drop_o  = mbe_i[P_TBUF];
        crc_zero_o[0] = mbe_i[P_CH1] | (mbe_i[P_TBUF] & tbuf_ch_i[0]);
        crc_zero_o[1] = mbe_i[P_CH2] | (mbe_i[P_TBUF] & tbuf_ch_i[1]);
    end
endmodule

// File: rtl/ecch_index_fsm.sv
module ecch_index_fsm
    import ecch_pkg::*;
#(
    parameter int BUF_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_scan_i,
    input  logic             cap_xfer_i,
    input  logic             cap_tbuf_i,
    input  logic [BUF_W-1:0] scan_buf_i,
    input  logic [BUF_W-1:0] xfer_buf_i,
    input  logic [BUF_W-1:0] tbuf_buf_i,
    input  logic             release_i,
    output logic             valid_o,
    output logic [BUF_W-1:0] idx_o
);
    idx_state_e       state_q, state_d;
    logic [BUF_W-1:0] idx_q, idx_d;
    logic             any_cap;
    logic [BUF_W-1:0] cap_val;

    always_comb begin
        any_cap = cap_scan_i | cap_xfer_i | cap_tbuf_i;
        if (cap_scan_i)      cap_val = scan_buf_i;
        else if (cap_xfer_i) cap_val = xfer_buf_i;
        else                 cap_val = tbuf_buf_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IDX_EMPTY;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            IDX_EMPTY: begin
                if (any_cap) begin          // T_CAPTURE
                    state_d = IDX_HELD;
                    idx_d   = cap_val;
                end
            end
            IDX_HELD: begin
                if (release_i) begin
                    if (any_cap) begin      // T_RECAPTURE
                        idx_d = cap_val;
                    end else begin          // T_RELEASE
                        state_d = IDX_EMPTY;
                        idx_d   = '0;
                    end
                end
            end
            default: begin
                state_d = IDX_EMPTY;
                idx_d   = '0;
            end
        endcase
    end

    always_comb begin
        valid_o = (state_q == IDX_HELD);
        idx_o   = idx_q;
    end

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IDX_HELD && !release_i) |=> ($stable(idx_q) && state_q == IDX_HELD)); // R10
    AST_IDX_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IDX_HELD && release_i && !any_cap) |=> (idx_q == '0)); // R10
endmodule

// File: rtl/ecch_sticky.sv
module ecch_sticky #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flag_o
);
    logic [W-1:0] flag_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q[i] <= 1'b0;
            else        flag_q[i] <= set_i[i] | (flag_q[i] & ~clr_i[i]);
        end

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !clr_i[i]) |=> flag_q[i]); // R9
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flag_q[i]); // R9
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/ecch_top.sv
module ecch_top
    import ecch_pkg::*;
#(
    parameter int BUF_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPATH-1:0] sbe_i,
    input  logic [NPATH-1:0] mbe_i,
    input  logic             xfer_data_only_i,
    input  logic [1:0]       tbuf_ch_i,
    input  logic [BUF_W-1:0] xfer_buf_i,
    input  logic [BUF_W-1:0] scan_buf_i,
    input  logic [BUF_W-1:0] tbuf_buf_i,
    input  logic             clr_we_i,
    input  logic [CLR_W-1:0] clr_mask_i,
    input  logic             irq_err_en_i,
    input  logic             irq_sbe_en_i,
    output logic [NFLAG-1:0] st_flags_o,
    output logic [NPATH-1:0] st_sbe_path_o,
    output logic [BUF_W-1:0] st_idx_o,
    output logic             irq_o,
    output logic             block_txreq_o,
    output logic             hold_data_o,
    output logic             skip_buf_o,
    output logic             frame_drop_o,
    output logic [1:0]       crc_zero_o
);
    fault_t              fault;
    logic [CLR_W-1:0]    clr_eff;
    logic [STICKY_W-1:0] st_set, st_clr, st_q;
    logic                idx_valid;

    ecch_path_decode u_dec (
        .mbe_i         (mbe_i),
        .data_only_i   (xfer_data_only_i),
        .tbuf_ch_i     (tbuf_ch_i),
        .fault_o       (fault),
        .block_txreq_o (block_txreq_o),
        .hold_data_o   (hold_data_o),
        .skip_buf_o    (skip_buf_o),
        .frame_drop_o  (frame_drop_o),
        .crc_zero_o    (crc_zero_o)
    );

    ecch_index_fsm #(.BUF_W(BUF_W)) u_idx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_scan_i (fault.cap_scan),
        .cap_xfer_i (fault.cap_xfer),
        .cap_tbuf_i (fault.cap_tbuf),
        .scan_buf_i (scan_buf_i),
        .xfer_buf_i (xfer_buf_i),
        .tbuf_buf_i (tbuf_buf_i),
        .release_i  (clr_eff[F_VALID]),
        .valid_o    (idx_valid),
        .idx_o      (st_idx_o)
    );

    // Sticky layout: [3:0] fault flags, [4] sbe, [5] err, [11:6] sbe location
    always_comb begin
        clr_eff = clr_we_i ? clr_mask_i : '0;
        st_set  = {sbe_i, (|sbe_i) | (|mbe_i), |sbe_i,
                   fault.ch2, fault.ch1, fault.mram, fault.ibf};
        st_clr  = {clr_eff[CLR_W-1:NFLAG], clr_eff[F_ERR], clr_eff[F_SBE],
                   clr_eff[F_CH2:F_IBF]};
    end

    ecch_sticky #(.W(STICKY_W)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (st_set),
        .clr_i  (st_clr),
        .flag_o (st_q)
    );

    always_comb begin
        st_flags_o    = {st_q[5], st_q[4], idx_valid, st_q[3:0]};
        st_sbe_path_o = st_q[STICKY_W-1:6];
        irq_o         = (st_flags_o[F_ERR] & irq_err_en_i) | (st_flags_o[F_SBE] & irq_sbe_en_i);
    end

    AST_ERR_ON_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        ((|mbe_i) || (|sbe_i)) |=> st_flags_o[F_ERR]); // R1
    AST_SBE_LOC: assert property (@(posedge clk) disable iff (!rst_n)
        (|sbe_i) |=> (st_flags_o[F_SBE] && (st_sbe_path_o != '0))); // R2
    AST_CAPTURE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (mbe_i[P_XFER] || mbe_i[P_SCAN] || mbe_i[P_TBUF]) |=> st_flags_o[F_VALID]); // R10
    AST_SCAN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_valid && mbe_i[P_SCAN]) |=> (st_idx_o == $past(scan_buf_i))); // R11
    AST_PULSE_END: assert property (@(posedge clk) disable iff (!rst_n)
        (mbe_i == '0) |-> (!block_txreq_o && !skip_buf_o && !frame_drop_o && crc_zero_o == 2'b00)); // R12
    AST_HOST_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (mbe_i == (NPATH'(1) << P_HOST)) |-> !(block_txreq_o || hold_data_o || skip_buf_o || frame_drop_o)); // R5
endmodule

// File: tb/sim_ecch_top.sv
module sim_ecch_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  sbe_i = '0, mbe_i = '0;
    logic        xfer_data_only_i = 1'b0;
    logic [1:0]  tbuf_ch_i = '0;
    logic [6:0]  xfer_buf_i = 7'h11, scan_buf_i = 7'h22, tbuf_buf_i = 7'h33;
    logic        clr_we_i = 1'b0;
    logic [12:0] clr_mask_i = '0;
    logic        irq_err_en_i = 1'b0, irq_sbe_en_i = 1'b0;
    logic [6:0]  st_flags_o;
    logic [5:0]  st_sbe_path_o;
    logic [6:0]  st_idx_o;
    logic        irq_o, block_txreq_o, hold_data_o, skip_buf_o, frame_drop_o;
    logic [1:0]  crc_zero_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ecch_top u0 (.*);

    // {sbe[6], mbe[6], data_only, tbuf_ch[2], pulses{block,hold,skip,drop,crc[2]}, flags[7], idx[7]}
    localparam int NV = 10;
    localparam logic [34:0] VEC [NV] = '{
        {6'b000000, 6'b000001, 1'b0, 2'b00, 6'b100000, 7'b1010001, 7'h11},
        {6'b000000, 6'b000001, 1'b1, 2'b00, 6'b110000, 7'b1010010, 7'h11},
        {6'b000000, 6'b000010, 1'b0, 2'b00, 6'b000000, 7'b1000001, 7'h00},
        {6'b000000, 6'b000100, 1'b0, 2'b00, 6'b001000, 7'b1010010, 7'h22},
        {6'b000000, 6'b001000, 1'b0, 2'b01, 6'b000101, 7'b1010010, 7'h33},
        {6'b000000, 6'b010000, 1'b0, 2'b00, 6'b000001, 7'b1000100, 7'h00},
        {6'b000000, 6'b100000, 1'b0, 2'b00, 6'b000010, 7'b1001000, 7'h00},
        {6'b000100, 6'b000000, 1'b0, 2'b00, 6'b000000, 7'b1100000, 7'h00},
        {6'b000000, 6'b001101, 1'b0, 2'b10, 6'b101110, 7'b1010011, 7'h22},
        {6'b000000, 6'b001001, 1'b1, 2'b11, 6'b110111, 7'b1010010, 7'h11}
    };

    function automatic string vtag(int i);
        case (i)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            5, 6: return "R8";
            7: return "R2";
            default: return "R11";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        clr_we_i = 1'b1;
        clr_mask_i = 13'h1FFF;
        @(negedge clk);
        clr_we_i = 1'b0;
        clr_mask_i = '0;
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R1, R9)
        check("R9 reset flags", 32'(st_flags_o), 32'h0);
        check("R10 reset idx", 32'(st_idx_o), 32'h0);
        check("R1 reset irq", 32'(irq_o), 32'h0);

        for (int i = 0; i < NV; i++) begin
            sbe_i = VEC[i][34:29];
            mbe_i = VEC[i][28:23];
            xfer_data_only_i = VEC[i][22];
            tbuf_ch_i = VEC[i][21:20];
            #2;
            check({vtag(i), " pulses"},
                  32'({block_txreq_o, hold_data_o, skip_buf_o, frame_drop_o, crc_zero_o}),
                  32'(VEC[i][19:14]));
            @(negedge clk);
            sbe_i = '0;
            mbe_i = '0;
            xfer_data_only_i = 1'b0;
            tbuf_ch_i = '0;
            #1;
            check({vtag(i), " flags"}, 32'(st_flags_o), 32'(VEC[i][13:7]));
            check({vtag(i), " idx"}, 32'(st_idx_o), 32'(VEC[i][6:0]));
            check("R12 pulse ends",
                  32'({block_txreq_o, hold_data_o, skip_buf_o, frame_drop_o, crc_zero_o}), 32'h0);
            clear_all();
        end

        // R2: location and its interrupt
        sbe_i = 6'b100010;
        @(negedge clk);
        sbe_i = '0;
        check("R2 sbe location", 32'(st_sbe_path_o), 32'h22);
        check("R2 irq off", 32'(irq_o), 32'h0);
        irq_sbe_en_i = 1'b1;
        #1;
        check("R2 irq sbe", 32'(irq_o), 32'h1);
        irq_sbe_en_i = 1'b0;
        clear_all();
        check("R9 clear all", 32'({st_flags_o, st_sbe_path_o}), 32'h0);

        // R1: general error interrupt
        mbe_i = 6'b000010;
        @(negedge clk);
        mbe_i = '0;
        check("R1 irq disabled", 32'(irq_o), 32'h0);
        irq_err_en_i = 1'b1;
        #1;
        check("R1 irq enabled", 32'(irq_o), 32'h1);
        // R9: partial clear leaves ibf, clears err
        clr_we_i = 1'b1;
        clr_mask_i = 13'h0040;
        @(negedge clk);
        clr_we_i = 1'b0;
        clr_mask_i = '0;
        check("R9 partial clear", 32'(st_flags_o), 32'h01);
        check("R1 irq after clear", 32'(irq_o), 32'h0);
        irq_err_en_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 sticky hold", 32'(st_flags_o), 32'h01);
        clear_all();

        // R9: set wins over same-cycle clear
        mbe_i = 6'b000010;
        clr_we_i = 1'b1;
        clr_mask_i = 13'h1FFF;
        @(negedge clk);
        mbe_i = '0;
        clr_we_i = 1'b0;
        clr_mask_i = '0;
        check("R9 set beats clear", 32'(st_flags_o), 32'h41);
        clear_all();

        // R10: first number held, later capture ignored
        mbe_i = 6'b000001;
        @(negedge clk);
        mbe_i = 6'b000100;
        @(negedge clk);
        mbe_i = '0;
        check("R10 first held", 32'(st_idx_o), 32'h11);
        check("R10 valid", 32'(st_flags_o[4]), 32'h1);
        clr_we_i = 1'b1;
        clr_mask_i = 13'h0010;
        @(negedge clk);
        clr_we_i = 1'b0;
        clr_mask_i = '0;
        check("R10 released idx", 32'(st_idx_o), 32'h0);
        check("R10 released valid", 32'(st_flags_o[4]), 32'h0);
        check("R10 other flags kept", 32'(st_flags_o), 32'h43);
        // recapture in the clearing cycle
        mbe_i = 6'b001000;
        @(negedge clk);
        mbe_i = 6'b000100;
        clr_we_i = 1'b1;
        clr_mask_i = 13'h0010;
        @(negedge clk);
        mbe_i = '0;
        clr_we_i = 1'b0;
        clr_mask_i = '0;
        check("R10 recapture idx", 32'(st_idx_o), 32'h22);
        check("R10 recapture valid", 32'(st_flags_o[4]), 32'h1);
        clear_all();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule